// File: doc/BRIEF.md
# ALU Condition Flag Unit

This block computes the 16-bit result of add, subtract and bitwise operations and keeps the condition flags of a 16-bit machine status word up to date. Each cycle an operation code and two operands are presented. The result appears combinationally on the same cycle. When the write enable is high, the status word takes its new value on the next rising clock edge.

Five flags live in the low bits: carry, overflow, less-than, equal and greater-than. The other eleven bits hold fields owned by other parts of the processor, and ALU operations pass them through unchanged. A status-load operation writes the whole word from operand A. This is how those fields get their values, and how software restores a saved word.

Two operation families have unusual flag rules. Add-with-carry and subtract-with-carry leave the three compare flags alone when the result is zero. A chained unsigned compare writes them only while the equal flag is set. Together these let a signed multi-word comparison run without branches: a signed compare on the top word, then one chained compare for each lower word.

Top module: `aluflag_top`

## Requirements
- R1: After reset the status word is 0x0000. Flag positions are C=bit 0, OVF=bit 1, LT=bit 2, EQ=bit 3, GT=bit 4. Bits 15:5 are pass-through fields.
- R2: Add (code 0) and add-immediate (code 2) give result A+B and set C to the carry out of bit 15 and OVF to two's-complement overflow. They set exactly one of LT/EQ/GT from the signed result compared with zero. Add-immediate sign-extends opB[7:0].
- R3: Subtract (code 3) gives A-B and sets C to 1 on an unsigned borrow (A<B). It sets OVF to signed overflow, and LT/EQ/GT from the signed result compared with zero.
- R4: Add-with-carry (code 1) gives A+B+C and subtract-with-carry (code 4) gives A-B-C, both using the stored C. Both always update C and OVF. On a nonzero result they set LT/GT from the sign and clear EQ. On a zero result LT, EQ and GT keep their values.
- R5: Signed compare (code 5) and compare-immediate (code 6) set exactly one of LT/EQ/GT from a signed comparison of A with B, and leave C and OVF unchanged. Compare-immediate sign-extends opB[7:0].
- R6: Chained compare (code 7) performs an unsigned compare of A with B and writes LT/EQ/GT only when EQ is 1 before the operation. When EQ is 0, LT, EQ and GT keep their values. C and OVF are never changed.
- R7: AND (8), AND-imm (9), OR (10), OR-imm (11), XOR (12), XOR-imm (13) and NOT of A (14) give the bitwise result. They set EQ when the result is zero, clear LT and GT, and keep C and OVF. The immediate forms zero-extend opB[7:0].
- R8: No ALU operation (codes 0 to 14) changes status bits 15:5.
- R9: When wrEn is low the status word does not change. The result output still shows the operation's value.
- R10: Status load (code 15) with wrEn high writes opA into the whole status word.
- R11: The result output is 0x0000 for compare codes 5, 6 and 7 and for status load code 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Status word takes the operation's update on the next edge |
| opCode | input | 4 | Operation code (see R2 to R11) |
| opA | input | 16 | First operand, or status word for load |
| opB | input | 16 | Second operand; low byte used by immediate codes |
| result | output | 16 | Combinational operation result |
| statusWord | output | 16 | Registered status word |

## Verification
A wrong flag is held in the status register, so it appears at the statusWord port one edge after the faulty update. It then stays there until a later operation overwrites that flag. Because add-with-carry, subtract-with-carry and the chained compare read the stored flags, a wrong carry or equal bit also spreads into later results and flags. The reference model is compared at every clock, so any divergence is reported in the cycle it first becomes visible. Long random runs with the pass-through fields loaded with nonzero values also catch a stray write to bits 15:5.

// File: rtl/aluflag_pkg.sv
package aluflag_pkg;

  localparam int STATUS_W  = 16;
  localparam int C_BIT     = 0;
  localparam int OVF_BIT   = 1;
  localparam int LT_BIT    = 2;
  localparam int EQ_BIT    = 3;
  localparam int GT_BIT    = 4;
  localparam int KEEP_LO   = 5;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_ADDI  = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBC  = 4'd4,
    OP_CMP   = 4'd5,
    OP_CMPI  = 4'd6,
    OP_CMPM  = 4'd7,
    OP_AND   = 4'd8,
    OP_ANDI  = 4'd9,
    OP_OR    = 4'd10,
    OP_ORI   = 4'd11,
    OP_XOR   = 4'd12,
    OP_XORI  = 4'd13,
    OP_NOT   = 4'd14,
    OP_LDSR  = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOT, K_PASS
  } kind_e;

  typedef enum logic [1:0] {
    X_NONE, X_SIGN, X_ZERO
  } ext_e;

  typedef enum logic [2:0] {
    F_ARITH, F_ARITHC, F_SCMP, F_UCHAIN, F_LOGIC, F_LOAD
  } rule_e;

  typedef struct packed {
    logic  wr;
    kind_e kind;
    ext_e  ext;
    logic  useCarry;
    logic  showResult;
    rule_e flagRule;
  } ctrl_s;

endpackage

// File: rtl/aluflag_ctrl.sv
module aluflag_ctrl
  import aluflag_pkg::*;
(
  input  logic       wrEn,
  input  logic [3:0] opCode,
  output ctrl_s      ctrl
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    ctrl            = '0;
    ctrl.wr         = wrEn;
    ctrl.kind       = K_PASS;
    ctrl.ext        = X_NONE;
    ctrl.useCarry   = 1'b0;
    ctrl.showResult = 1'b1;
    ctrl.flagRule   = F_ARITH;
    case (op)
      OP_ADD:  begin ctrl.kind = K_ADD; end
      OP_ADDC: begin ctrl.kind = K_ADD; ctrl.useCarry = 1'b1; ctrl.flagRule = F_ARITHC; end
      OP_ADDI: begin ctrl.kind = K_ADD; ctrl.ext = X_SIGN; end
      OP_SUB:  begin ctrl.kind = K_SUB; end
      OP_SUBC: begin ctrl.kind = K_SUB; ctrl.useCarry = 1'b1; ctrl.flagRule = F_ARITHC; end
      OP_CMP:  begin ctrl.kind = K_SUB; ctrl.showResult = 1'b0; ctrl.flagRule = F_SCMP; end
      OP_CMPI: begin ctrl.kind = K_SUB; ctrl.ext = X_SIGN; ctrl.showResult = 1'b0; ctrl.flagRule = F_SCMP; end
      OP_CMPM: begin ctrl.kind = K_SUB; ctrl.showResult = 1'b0; ctrl.flagRule = F_UCHAIN; end
      OP_AND:  begin ctrl.kind = K_AND; ctrl.flagRule = F_LOGIC; end
      OP_ANDI: begin ctrl.kind = K_AND; ctrl.ext = X_ZERO; ctrl.flagRule = F_LOGIC; end
      OP_OR:   begin ctrl.kind = K_OR;  ctrl.flagRule = F_LOGIC; end
      OP_ORI:  begin ctrl.kind = K_OR;  ctrl.ext = X_ZERO; ctrl.flagRule = F_LOGIC; end
      OP_XOR:  begin ctrl.kind = K_XOR; ctrl.flagRule = F_LOGIC; end
      OP_XORI: begin ctrl.kind = K_XOR; ctrl.ext = X_ZERO; ctrl.flagRule = F_LOGIC; end
      OP_NOT:  begin ctrl.kind = K_NOT; ctrl.flagRule = F_LOGIC; end
      OP_LDSR: begin ctrl.kind = K_PASS; ctrl.showResult = 1'b0; ctrl.flagRule = F_LOAD; end
      default: begin ctrl.kind = K_PASS; ctrl.wr = 1'b0; end
    endcase
  end

endmodule

// File: rtl/aluflag_dp.sv
module aluflag_dp
  import aluflag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [STATUS_W-1:0] statusQ
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0]   opBx;
  logic [DATA_W-1:0]   addend;
  logic                cinStored;
  logic                cinEff;
  logic [DATA_W:0]     sumWide;
  logic [DATA_W-1:0]   sumVal;
  logic                carryOut;
  logic                borrow;
  logic                ovf;
  logic [DATA_W-1:0]   aluRes;
  logic                isZero;
  logic                isNeg;
  logic                sLess;
  logic [STATUS_W-1:0] statusNext;
  logic [STATUS_W-1:0] statusD;

  // operand B extension for immediate forms
  always_comb begin
    case (ctrl.ext)
      X_SIGN:  opBx = {{EXT_W{opB[IMM_W-1]}}, opB[IMM_W-1:0]};
      X_ZERO:  opBx = {{EXT_W{1'b0}}, opB[IMM_W-1:0]};
      default: opBx = opB;
    endcase
  end

  // shared adder: subtraction as A + ~B + ~borrowIn
  assign cinStored = ctrl.useCarry & statusQ[C_BIT];
  assign addend    = (ctrl.kind == K_SUB) ? ~opBx : opBx;
  assign cinEff    = (ctrl.kind == K_SUB) ? ~cinStored : cinStored;
  assign sumWide   = {1'b0, opA} + {1'b0, addend} + {{DATA_W{1'b0}}, cinEff};
  assign sumVal    = sumWide[DATA_W-1:0];
  assign carryOut  = sumWide[DATA_W];
  assign borrow    = ~carryOut;
  assign ovf       = (opA[MSB] == addend[MSB]) && (sumVal[MSB] != opA[MSB]);

  always_comb begin
    case (ctrl.kind)
      K_ADD, K_SUB: aluRes = sumVal;
      K_AND:        aluRes = opA & opBx;
      K_OR:         aluRes = opA | opBx;
      K_XOR:        aluRes = opA ^ opBx;
      K_NOT:        aluRes = ~opA;
      default:      aluRes = '0;
    endcase
  end

  assign result = ctrl.showResult ? aluRes : '0;

  assign isZero = (aluRes == '0);
  assign isNeg  = aluRes[MSB];
  assign sLess  = sumVal[MSB] ^ ovf;

  // next status word
  always_comb begin
    statusNext = statusQ;
    case (ctrl.flagRule)
      F_ARITH: begin
        statusNext[C_BIT]   = (ctrl.kind == K_SUB) ? borrow : carryOut;
        statusNext[OVF_BIT] = ovf;
        statusNext[LT_BIT]  = isNeg;
        statusNext[EQ_BIT]  = isZero;
        statusNext[GT_BIT]  = ~isNeg & ~isZero;
      end
      F_ARITHC: begin
        statusNext[C_BIT]   = (ctrl.kind == K_SUB) ? borrow : carryOut;
        statusNext[OVF_BIT] = ovf;
        if (!isZero) begin
          statusNext[LT_BIT] = isNeg;
          statusNext[EQ_BIT] = 1'b0;
          statusNext[GT_BIT] = ~isNeg;
        end
      end
      F_SCMP: begin
        statusNext[LT_BIT] = sLess;
        statusNext[EQ_BIT] = isZero;
        statusNext[GT_BIT] = ~sLess & ~isZero;
      end
      F_UCHAIN: begin
        if (statusQ[EQ_BIT]) begin
          statusNext[LT_BIT] = borrow;
          statusNext[EQ_BIT] = isZero;
          statusNext[GT_BIT] = ~borrow & ~isZero;
        end
      end
      F_LOGIC: begin
        statusNext[LT_BIT] = 1'b0;
        statusNext[EQ_BIT] = isZero;
        statusNext[GT_BIT] = 1'b0;
      end
      F_LOAD: begin
        statusNext = opA[STATUS_W-1:0];
      end
      default: statusNext = statusQ;
    endcase
  end

  assign statusD = ctrl.wr ? statusNext : statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusD;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusQ == '0));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wr |=> $stable(statusQ));

  // R8
  upper_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.flagRule != F_LOAD) |=> $stable(statusQ[STATUS_W-1:KEEP_LO]));

  // R2
  arith_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wr && ctrl.flagRule == F_ARITH) |=> ($countones(statusQ[GT_BIT:LT_BIT]) == 1));

  // R5
  cmp_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wr && ctrl.flagRule == F_SCMP) |=>
      ($countones(statusQ[GT_BIT:LT_BIT]) == 1) && $stable(statusQ[OVF_BIT:C_BIT]));

  // R6
  chain_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wr && ctrl.flagRule == F_UCHAIN && !statusQ[EQ_BIT]) |=> $stable(statusQ[GT_BIT:C_BIT]));

  // R7
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wr && ctrl.flagRule == F_LOGIC) |=>
      !statusQ[LT_BIT] && !statusQ[GT_BIT] && $stable(statusQ[OVF_BIT:C_BIT]));

  // R11
  silent_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.showResult |-> (result == '0));

endmodule

// File: rtl/aluflag_top.sv
module aluflag_top
  import aluflag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [STATUS_W-1:0] statusWord
);

  ctrl_s ctrl;

  aluflag_ctrl u_ctrl (
    .wrEn   (wrEn),
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  aluflag_dp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .statusQ (statusWord)
  );

endmodule

// File: tb/test_aluflag_top.sv
module test_aluflag_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [15:0] result;
  logic [15:0] statusWord;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  logic [15:0] mStatus = '0;
  string lastTag = "R1";

  aluflag_top i_aluflag_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .opCode(opCode),
    .opA(opA), .opB(opB), .result(result), .statusWord(statusWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check16(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [3:0] op, input logic we);
    if (!we && op != 4'd15) return "R9";
    case (op)
      4'd0, 4'd2: return "R2";
      4'd3:       return "R3";
      4'd1, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7:       return "R6";
      4'd15:      return we ? "R10" : "R9";
      default:    return "R7";
    endcase
  endfunction

  // behavioural reference of one operation
  function automatic void refModel(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                                   input logic [15:0] st, output logic [15:0] res, output logic [15:0] nst);
    logic [15:0] bx;
    int cin, full, sfull, sr;
    logic [15:0] r;
    nst = st;
    res = '0;
    bx = b;
    if (op == 4'd2 || op == 4'd6) bx = {{8{b[7]}}, b[7:0]};
    if (op == 4'd9 || op == 4'd11 || op == 4'd13) bx = {8'h00, b[7:0]};
    cin = (op == 4'd1 || op == 4'd4) ? int'(st[0]) : 0;
    case (op)
      4'd0, 4'd1, 4'd2: begin
        full  = int'(a) + int'(bx) + cin;
        sfull = int'($signed(a)) + int'($signed(bx)) + cin;
        r = full[15:0];
        res = r;
        nst[0] = (full > 65535);
        nst[1] = (sfull > 32767) || (sfull < -32768);
        sr = int'($signed(r));
        if (op != 4'd1 || r != 0) begin
          nst[2] = (sr < 0); nst[3] = (sr == 0); nst[4] = (sr > 0);
        end
      end
      4'd3, 4'd4: begin
        full  = int'(a) - int'(bx) - cin;
        sfull = int'($signed(a)) - int'($signed(bx)) - cin;
        r = full[15:0];
        res = r;
        nst[0] = (full < 0);
        nst[1] = (sfull > 32767) || (sfull < -32768);
        sr = int'($signed(r));
        if (op != 4'd4 || r != 0) begin
          nst[2] = (sr < 0); nst[3] = (sr == 0); nst[4] = (sr > 0);
        end
      end
      4'd5, 4'd6: begin
        nst[2] = ($signed(a) <  $signed(bx));
        nst[3] = (a == bx);
        nst[4] = ($signed(a) >  $signed(bx));
      end
      4'd7: begin
        if (st[3]) begin
          nst[2] = (a < b); nst[3] = (a == b); nst[4] = (a > b);
        end
      end
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14: begin
        if (op == 4'd8 || op == 4'd9)        r = a & bx;
        else if (op == 4'd10 || op == 4'd11) r = a | bx;
        else if (op == 4'd12 || op == 4'd13) r = a ^ bx;
        else                                 r = ~a;
        res = r;
        nst[2] = 1'b0; nst[3] = (r == 0); nst[4] = 1'b0;
      end
      default: nst = a;
    endcase
  endfunction

  // one operation per clock; status compared every clock
  task automatic step(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b, input logic we);
    logic [15:0] eRes, eSt;
    string tag;
    @(negedge clk);
    check16(lastTag, "statusWord", statusWord, mStatus);
    opCode = op; opA = a; opB = b; wrEn = we;
    tag = tagOf(op, we);
    refModel(op, a, b, mStatus, eRes, eSt);
    #1;
    check16((op == 4'd5 || op == 4'd6 || op == 4'd7 || op == 4'd15) ? "R11" : tag, "result", result, eRes);
    if (we) mStatus = eSt;
    lastTag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check16("R1", "reset status", statusWord, 16'h0000);

    // R2 add overflow, carry to zero, sign-extended immediate
    step(4'd0, 16'h7FFF, 16'h0001, 1);
    step(4'd0, 16'hFFFF, 16'h0001, 1);
    step(4'd2, 16'h0005, 16'h00FE, 1);
    // R3 borrow and signed overflow
    step(4'd3, 16'h0003, 16'h0005, 1);
    step(4'd3, 16'h8000, 16'h0001, 1);
    // R4 carry-in use, zero result keeps compare flags
    step(4'd15, 16'h0009, 16'h0000, 1);
    step(4'd1, 16'hFFFF, 16'h0000, 1);
    step(4'd1, 16'h0001, 16'h0001, 1);
    step(4'd15, 16'h0011, 16'h0000, 1);
    step(4'd4, 16'h0001, 16'h0000, 1);
    step(4'd4, 16'h0000, 16'h0001, 1);
    // R5 signed compares, immediate sign extension
    step(4'd5, 16'hFFFF, 16'h0001, 1);
    step(4'd6, 16'h0001, 16'h00FF, 1);
    // R6 chained compare, open and blocked
    step(4'd5, 16'h1234, 16'h1234, 1);
    step(4'd7, 16'h0000, 16'hFFFF, 1);
    step(4'd7, 16'hFFFF, 16'h0000, 1);
    // R7 logic with preset C/OVF and pass-through fields
    step(4'd15, 16'hFFE3, 16'h0000, 1);
    step(4'd9, 16'h00F0, 16'hFF0F, 1);
    step(4'd11, 16'h8000, 16'hFF01, 1);
    step(4'd13, 16'h00FF, 16'h12FF, 1);
    step(4'd14, 16'hFFFF, 16'h0000, 1);
    step(4'd0, 16'h8000, 16'h8000, 1);
    step(4'd7, 16'h0001, 16'h0001, 1);
    @(negedge clk);
    // R8 upper fields survive ALU ops
    check16("R8", "status[15:5]", {statusWord[15:5], 5'b0}, 16'hFFE0);
    // R9 idle write enable
    step(4'd0, 16'h7FFF, 16'h7FFF, 0);
    step(4'd3, 16'h0000, 16'h0001, 0);
    step(4'd15, 16'h0000, 16'h0000, 0);

    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [15:0] a, b;
      op = 4'($urandom % 16);
      a = 16'($urandom);
      b = ((i % 5) == 0) ? a : 16'($urandom);
      step(op, a, b, ($urandom % 8) != 0);
    end
    @(negedge clk);
    check16(lastTag, "final statusWord", statusWord, mStatus);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule